// File: doc/BRIEF.md
# Watermark-Gated Interrupt Controller

This block gathers interrupt causes from a packet receive path and a packet transmit path and turns them into one interrupt request to the CPU. Each cause arrives as a single-cycle event. Some events are qualified by a FIFO occupancy compare. The block latches each event into a sticky status register. Software can read the status register, which clears it, or write ones to it to clear chosen bits. A mask register selects which status bits may raise the request.

Two causes use hysteresis. The receive-above-mark cause reaches the CPU only after the receive FIFO has been reported empty. The transmit-below-mark cause reaches the CPU only after a push has left the transmit FIFO nearly full. Each of these conditions is held in an arm flag. An arm flag is spent by the next evaluation, which happens on any cycle in which a cause is posted.

Posting is either urgent or lazy. If the qualified pending set holds a cause from the urgent group, the request rises after the next clock edge. Otherwise the request rises after a programmable number of cycles. A lazy posting still waiting is dropped if the masked status becomes empty. A global enable gates the request pin and does not affect the status.

Top module: `wmic_top`

## Requirements
- R1: Each posted cause sets its status bit, and the bit stays set until it is cleared. Bit positions: 0 rx packet, 1 rx above mark, 2 rx DMA done, 3 tx packet sent, 4 tx below mark, 5 tx nearly full, 6 tx DMA done. `mask_rdata` shows the mask, and a mask write takes effect at the next edge.
- R2: A cycle with `stat_rd` high clears the whole status at the next edge. A cause posted in the same cycle survives the clear.
- R3: A status write clears exactly the bits that are one both in `stat_wdata` and in the current status. Other bits are unchanged.
- R4: After reset the status is 0, the mask is 0x16 (rx above mark, rx DMA done, tx below mark), `irq` is low and both arm flags are clear.
- R5: `rx_arrive` always posts bit 0. It also posts bit 1 when `rx_level >= rx_mark`.
- R6: `tx_sent` always posts bit 3. It also posts bit 4 when `tx_level < tx_mark`.
- R7: `tx_push` with `tx_free < tx_max_copy` posts bit 5 and sets the tx arm flag. The set takes priority over consumption in the same cycle.
- R8: Bit 1 counts toward the request only while the rx arm flag is set. `rx_drained` sets this flag. Any cycle that posts a cause clears it.
- R9: Bit 4 counts toward the request only while the tx arm flag is set. Any cycle that posts a cause clears this flag.
- R10: If the qualified pending set of an evaluation contains a bit of the urgent group (`URGENT`, default bits 2 and 6), the request line is set at that edge. `irq` is then high from the next cycle.
- R11: Otherwise the line is set `delay_cycles` edges after the evaluating edge. A value of 0 means at that edge.
- R12: A lazy posting that is still waiting is cancelled if status AND mask becomes zero. The line then stays low.
- R13: `irq` equals the request line AND `intr_en`. Dropping `intr_en` does not change the status.
- R14: The request line clears at the edge at which status AND mask becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_en | input | 1 | Global request enable |
| delay_cycles | input | DLY_W | Lazy posting delay in cycles |
| rx_arrive | input | 1 | Packet arrived at rx FIFO |
| rx_level | input | LVL_W | Rx FIFO occupancy at arrival |
| rx_mark | input | LVL_W | Rx high mark |
| rx_drained | input | 1 | Rx FIFO went empty; arms rx flag |
| rx_dma_done | input | 1 | Rx DMA finished |
| tx_sent | input | 1 | Packet left tx FIFO |
| tx_level | input | LVL_W | Tx FIFO occupancy after send |
| tx_mark | input | LVL_W | Tx low mark |
| tx_push | input | 1 | Packet pushed into tx FIFO |
| tx_free | input | LVL_W | Free tx space after push |
| tx_max_copy | input | LVL_W | Largest copy size |
| tx_dma_done | input | 1 | Tx DMA finished |
| stat_rd | input | 1 | Status read (clears status) |
| stat_wr | input | 1 | Status write-one-to-clear |
| stat_wdata | input | 7 | Status write data |
| stat_rdata | output | 7 | Status register |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 7 | Mask write data |
| mask_rdata | output | 7 | Mask register |
| irq | output | 1 | CPU interrupt request |

## Verification
The hardest situation to reach is the hysteresis gate. A rx-above-mark event alone must never raise `irq`. After `rx_drained` the same event must raise `irq` exactly once, and a repeat without a new drain must stay silent. The stimulus builds this sequence with explicit drain pulses between arrivals and clears the status in between.

Cancellation of a lazy post is reached by clearing the status partway through a running delay. The cycle-accurate behavioural model then confirms that `irq` never rises.

// File: rtl/wmic_pkg.sv
package wmic_pkg;
  localparam int NCAUSE = 7;
  localparam int C_RX_PKT  = 0;
  localparam int C_RX_HIGH = 1;
  localparam int C_RX_DMA  = 2;
  localparam int C_TX_PKT  = 3;
  localparam int C_TX_LOW  = 4;
  localparam int C_TX_FULL = 5;
  localparam int C_TX_DMA  = 6;
  typedef logic [NCAUSE-1:0] cause_t;
  localparam cause_t MASK_AT_RESET = cause_t'((1 << C_RX_HIGH) | (1 << C_RX_DMA) | (1 << C_TX_LOW));
  localparam cause_t URGENT_DEFAULT = cause_t'((1 << C_RX_DMA) | (1 << C_TX_DMA));
  // index of each hysteresis arm flag
  localparam int ARM_RX = 0;
  localparam int ARM_TX = 1;
  localparam int NARM = 2;
endpackage

// File: rtl/wmic_cause_gen.sv
module wmic_cause_gen
  import wmic_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             rx_arrive,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_mark,
  input  logic             rx_dma_done,
  input  logic             tx_sent,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_mark,
  input  logic             tx_push,
  input  logic [LVL_W-1:0] tx_free,
  input  logic [LVL_W-1:0] tx_max_copy,
  input  logic             tx_dma_done,
  output cause_t           post,
  output logic             tx_nearly_full
);
  always_comb begin
    tx_nearly_full    = tx_push && (tx_free < tx_max_copy);
    post              = '0;
    post[C_RX_PKT]    = rx_arrive;
    post[C_RX_HIGH]   = rx_arrive && (rx_level >= rx_mark);
    post[C_RX_DMA]    = rx_dma_done;
    post[C_TX_PKT]    = tx_sent;
    post[C_TX_LOW]    = tx_sent && (tx_level < tx_mark);
    post[C_TX_FULL]   = tx_nearly_full;
    post[C_TX_DMA]    = tx_dma_done;
  end
endmodule

// File: rtl/wmic_arm_flag.sv
module wmic_arm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic spend,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)     armed <= 1'b0;
    else if (arm)   armed <= 1'b1;
    else if (spend) armed <= 1'b0;
  end
endmodule

// File: rtl/wmic_post_timer.sv
module wmic_post_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             urgent,
  input  logic             lazy,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic             waiting;
  logic [DLY_W-1:0] left;

  always_comb begin
    fire = 1'b0;
    if (!kill) begin
      if (waiting && left == '0) fire = 1'b1;
      if (!waiting && lazy && dly == '0) fire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      left    <= '0;
    end else if (kill || urgent) begin
      waiting <= 1'b0;
    end else if (waiting) begin
      if (left == '0) waiting <= 1'b0;
      else            left    <= left - 1'b1;
    end else if (lazy && dly != '0) begin
      waiting <= 1'b1;
      left    <= dly - 1'b1;
    end
  end
endmodule

// File: rtl/wmic_top.sv
module wmic_top
  import wmic_pkg::*;
#(
  parameter int     LVL_W  = 8,
  parameter int     DLY_W  = 8,
  parameter cause_t URGENT = URGENT_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intr_en,
  input  logic [DLY_W-1:0]  delay_cycles,
  input  logic              rx_arrive,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_mark,
  input  logic              rx_drained,
  input  logic              rx_dma_done,
  input  logic              tx_sent,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_mark,
  input  logic              tx_push,
  input  logic [LVL_W-1:0]  tx_free,
  input  logic [LVL_W-1:0]  tx_max_copy,
  input  logic              tx_dma_done,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [NCAUSE-1:0] stat_wdata,
  output logic [NCAUSE-1:0] stat_rdata,
  input  logic              mask_wr,
  input  logic [NCAUSE-1:0] mask_wdata,
  output logic [NCAUSE-1:0] mask_rdata,
  output logic              irq
);
  cause_t    post, stat_q, mask_q, stat_d, mask_d, clr, live, gated;
  logic      tx_nearly_full, evaluate, req, urgent, lazy, kill, fire, line_q;
  logic [NARM-1:0] arm_set, arm_q;

  wmic_cause_gen #(.LVL_W(LVL_W)) u_causes (
    .rx_arrive(rx_arrive), .rx_level(rx_level), .rx_mark(rx_mark),
    .rx_dma_done(rx_dma_done), .tx_sent(tx_sent), .tx_level(tx_level),
    .tx_mark(tx_mark), .tx_push(tx_push), .tx_free(tx_free),
    .tx_max_copy(tx_max_copy), .tx_dma_done(tx_dma_done),
    .post(post), .tx_nearly_full(tx_nearly_full)
  );

  assign arm_set[ARM_RX] = rx_drained;
  assign arm_set[ARM_TX] = tx_nearly_full;

  for (genvar g = 0; g < NARM; g++) begin : g_arm
    wmic_arm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .arm(arm_set[g]), .spend(evaluate), .armed(arm_q[g])
    );
  end

  always_comb begin
    if (stat_rd)      clr = '1;
    else if (stat_wr) clr = stat_wdata;
    else              clr = '0;
    stat_d   = (stat_q & ~clr) | post;
    mask_d   = mask_wr ? mask_wdata : mask_q;
    live     = stat_d & mask_d;
    evaluate = |post;
    gated    = live;
    // hysteresis: watermark causes pass only with an armed flag
    gated[C_RX_HIGH] = live[C_RX_HIGH] & arm_q[ARM_RX];
    gated[C_TX_LOW]  = live[C_TX_LOW]  & arm_q[ARM_TX];
    req    = evaluate && (|gated);
    urgent = req && (|(gated & URGENT));
    lazy   = req && !urgent;
    kill   = (live == '0);
  end

  wmic_post_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kill(kill), .urgent(urgent), .lazy(lazy),
    .dly(delay_cycles), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_AT_RESET;
      line_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      line_q <= kill ? 1'b0 : (line_q | urgent | fire);
    end
  end

  assign stat_rdata = stat_q;
  assign mask_rdata = mask_q;
  assign irq        = line_q & intr_en;
endmodule

// File: rtl/wmic_chk.sv
module wmic_chk
  import wmic_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intr_en,
  input logic              irq,
  input logic              line_q,
  input logic              tx_armed,
  input logic              rx_arrive,
  input logic              rx_dma_done,
  input logic              tx_sent,
  input logic              tx_push,
  input logic [LVL_W-1:0]  tx_free,
  input logic [LVL_W-1:0]  tx_max_copy,
  input logic              tx_dma_done,
  input logic              stat_rd,
  input logic              mask_wr,
  input logic [NCAUSE-1:0] stat_rdata,
  input logic [NCAUSE-1:0] mask_rdata
);
  // R13
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> intr_en);

  // R2
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_arrive && !rx_dma_done && !tx_sent && !tx_push && !tx_dma_done)
    |=> (stat_rdata == '0));

  // R1
  post_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_done |=> stat_rdata[C_TX_DMA]);

  // R10
  urgent_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_done && mask_rdata[C_RX_DMA] && !mask_wr) |=> line_q);

  // R14
  line_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> ((stat_rdata & mask_rdata) != '0));

  // R7
  tx_arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && (tx_free < tx_max_copy)) |=> tx_armed);
endmodule

bind wmic_top wmic_chk #(.LVL_W(LVL_W)) u_wmic_chk (
  .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .irq(irq), .line_q(line_q),
  .tx_armed(arm_q[1]), .rx_arrive(rx_arrive), .rx_dma_done(rx_dma_done),
  .tx_sent(tx_sent), .tx_push(tx_push), .tx_free(tx_free),
  .tx_max_copy(tx_max_copy), .tx_dma_done(tx_dma_done), .stat_rd(stat_rd),
  .mask_wr(mask_wr), .stat_rdata(stat_rdata), .mask_rdata(mask_rdata)
);

// File: tb/test_wmic_top.sv
`timescale 1ns/1ps
module test_wmic_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       intr_en = 1'b1;
  logic [7:0] delay_cycles = 8'd5;
  logic       rx_arrive = 0, rx_drained = 0, rx_dma_done = 0;
  logic [7:0] rx_level = 8'd8, rx_mark = 8'd4;
  logic       tx_sent = 0, tx_push = 0, tx_dma_done = 0;
  logic [7:0] tx_level = 8'd5, tx_mark = 8'd3, tx_free = 8'd10, tx_max_copy = 8'd4;
  logic       stat_rd = 0, stat_wr = 0, mask_wr = 0;
  logic [6:0] stat_wdata = '0, mask_wdata = '0;
  logic [6:0] stat_rdata, mask_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wmic_top i_wmic_top (
    .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .delay_cycles(delay_cycles),
    .rx_arrive(rx_arrive), .rx_level(rx_level), .rx_mark(rx_mark),
    .rx_drained(rx_drained), .rx_dma_done(rx_dma_done), .tx_sent(tx_sent),
    .tx_level(tx_level), .tx_mark(tx_mark), .tx_push(tx_push), .tx_free(tx_free),
    .tx_max_copy(tx_max_copy), .tx_dma_done(tx_dma_done), .stat_rd(stat_rd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int m_stat, m_mask, m_line, m_wait, m_cnt;
  bit m_rxa, m_txa;
  always @(posedge clk) begin
    int p, clr, sn, mn, live, g;
    bit ev, req, urg, lazy, kill, fire, txset;
    if (!rst_n) begin
      m_stat = 0; m_mask = 'h16; m_line = 0; m_wait = 0; m_cnt = 0; m_rxa = 0; m_txa = 0;
    end else begin
      txset = tx_push && (tx_free < tx_max_copy);
      p = 0;
      if (rx_arrive) p |= 'h01;
      if (rx_arrive && rx_level >= rx_mark) p |= 'h02;
      if (rx_dma_done) p |= 'h04;
      if (tx_sent) p |= 'h08;
      if (tx_sent && tx_level < tx_mark) p |= 'h10;
      if (txset) p |= 'h20;
      if (tx_dma_done) p |= 'h40;
      clr = stat_rd ? 'h7f : (stat_wr ? int'(stat_wdata) : 0);
      sn = (m_stat & ~clr & 'h7f) | p;
      mn = mask_wr ? int'(mask_wdata) : m_mask;
      live = sn & mn;
      ev = (p != 0);
      g = live;
      if (!m_rxa) g &= ~'h02;
      if (!m_txa) g &= ~'h10;
      req = ev && (g != 0);
      urg = req && ((g & 'h44) != 0);
      lazy = req && !urg;
      kill = (live == 0);
      fire = 0;
      if (!kill && m_wait != 0 && m_cnt == 0) fire = 1;
      if (!kill && m_wait == 0 && lazy && delay_cycles == 0) fire = 1;
      if (kill || urg) m_wait = 0;
      else if (m_wait != 0) begin
        if (m_cnt == 0) m_wait = 0; else m_cnt--;
      end else if (lazy && delay_cycles != 0) begin
        m_wait = 1; m_cnt = int'(delay_cycles) - 1;
      end
      m_line = kill ? 0 : ((m_line != 0 || urg || fire) ? 1 : 0);
      if (rx_drained) m_rxa = 1; else if (ev) m_rxa = 0;
      if (txset) m_txa = 1; else if (ev) m_txa = 0;
      m_stat = sn; m_mask = mn;
    end
  end

  // every-cycle comparison, taken away from both clock edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(int'(stat_rdata) == m_stat, "R1 model status", stat_rdata, m_stat);
      chk(int'(mask_rdata) == m_mask, "R1 model mask", mask_rdata, m_mask);
      chk(irq == (m_line != 0 && intr_en), "R13 model irq", irq, (m_line != 0 && intr_en));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_clear();
    stat_rd = 1; step(); stat_rd = 0;
  endtask

  // pulse one event and count cycles until irq rises
  task automatic latency(input int which, output int k);
    case (which)
      0: rx_arrive = 1;
      1: rx_dma_done = 1;
      default: tx_sent = 1;
    endcase
    step();
    rx_arrive = 0; rx_dma_done = 0; tx_sent = 0;
    k = 1;
    #1;
    while (!irq && k < 40) begin step(); #1; k++; end
  endtask

  initial begin
    int k;
    step(3);
    rst_n = 1;
    #1;
    // R4
    chk(stat_rdata == 0, "R4 status after reset", stat_rdata, 0);
    chk(mask_rdata == 7'h16, "R4 mask after reset", mask_rdata, 'h16);
    chk(irq == 0, "R4 irq after reset", irq, 0);

    // R5 above mark, no arm: R8 suppression
    rx_arrive = 1; step(); rx_arrive = 0; #1;
    chk(stat_rdata == 7'h03, "R5 arrival above mark", stat_rdata, 'h03);
    step(8); #1;
    chk(irq == 0, "R8 unarmed rx high stays silent", irq, 0);
    read_clear(); #1;
    chk(stat_rdata == 0, "R2 read clears status", stat_rdata, 0);

    // R5 below mark
    rx_level = 8'd2;
    rx_arrive = 1; step(); rx_arrive = 0; #1;
    chk(stat_rdata == 7'h01, "R5 arrival below mark", stat_rdata, 'h01);
    read_clear();

    // R8 armed, R11 delay of 5
    rx_level = 8'd8;
    rx_drained = 1; step(); rx_drained = 0;
    latency(0, k);
    chk(k == 6, "R11 lazy post latency", k, 6);
    read_clear(); #1;
    chk(irq == 0, "R14 line drops when pending empty", irq, 1'b0);
    latency(0, k);
    chk(k == 40, "R8 arm flag spent by evaluation", k, 40);
    read_clear();

    // R10 urgent
    latency(1, k);
    chk(k == 1, "R10 urgent post latency", k, 1);

    // R3 write-one-to-clear
    rx_level = 8'd2;
    rx_arrive = 1; step(); rx_arrive = 0;
    stat_wdata = 7'h04; stat_wr = 1; step(); stat_wr = 0; #1;
    chk(stat_rdata == 7'h01, "R3 selective clear", stat_rdata, 'h01);
    chk(irq == 0, "R14 drop after selective clear", irq, 0);
    stat_wdata = 7'h02; stat_wr = 1; step(); stat_wr = 0; #1;
    chk(stat_rdata == 7'h01, "R3 clear of unset bit", stat_rdata, 'h01);
    read_clear();

    // R12 cancel
    rx_level = 8'd8;
    rx_drained = 1; step(); rx_drained = 0;
    rx_arrive = 1; step(); rx_arrive = 0;
    step(2);
    read_clear();
    step(10); #1;
    chk(irq == 0, "R12 cancelled lazy post", irq, 0);

    // R7 / R6 / R9
    tx_free = 8'd2;
    tx_push = 1; step(); tx_push = 0; #1;
    chk(stat_rdata == 7'h20, "R7 nearly full posted", stat_rdata, 'h20);
    read_clear();
    tx_level = 8'd1;
    latency(2, k);
    chk(k == 6, "R9 armed tx low latency", k, 6);
    chk(stat_rdata == 7'h18, "R6 send below mark", stat_rdata, 'h18);
    read_clear();
    latency(2, k);
    chk(k == 40, "R9 tx arm spent", k, 40);
    read_clear();

    // R13 enable gating
    intr_en = 0;
    rx_dma_done = 1; step(); rx_dma_done = 0;
    step(3); #1;
    chk(irq == 0, "R13 irq held low when disabled", irq, 0);
    chk(stat_rdata == 7'h04, "R13 status kept when disabled", stat_rdata, 'h04);
    intr_en = 1; #1;
    chk(irq == 1, "R13 irq follows enable", irq, 1);
    read_clear();

    // R1 mask write and combined posts
    mask_wdata = 7'h7f; mask_wr = 1; step(); mask_wr = 0;
    tx_level = 8'd5;
    tx_dma_done = 1; rx_dma_done = 1; tx_sent = 1; step();
    tx_dma_done = 0; rx_dma_done = 0; tx_sent = 0; #1;
    chk(mask_rdata == 7'h7f, "R1 mask write", mask_rdata, 'h7f);
    chk(stat_rdata == 7'h4c, "R1 combined posts", stat_rdata, 'h4c);
    read_clear();
    step(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule